// File: doc/BRIEF.md
# Two-Entry Return Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small controller's core. Whenever the core takes a subroutine call or acknowledges an interrupt, it strobes `push_i` with the address to return to on `pc_i`. Whenever it executes a return or a return-from-interrupt, it strobes `pop_i` and loads the program counter from `ret_addr_o`. The stack has exactly two levels and holds nothing but program counter values. The core has no path to read or write the entries or the level count.

The block also decides whether an interrupt may be taken. A pending, enabled request on `irq_req_i` is passed to `irq_ok_o` only while a free level remains. While both levels are occupied the request is held off. Its flag stays set outside this block, and the acknowledge is granted on the cycle after a return frees a level.

A call made while the stack is full is still carried out. The oldest address is dropped and the newer one moves down, so the two most recent return addresses survive. A return made on an empty stack does not wrap the level count.

Top module: `ret_stack_top`

## Requirements
- R1: After reset the stack is empty: `full_o` is 0, `ret_addr_o` is 0, and `irq_ok_o` equals `irq_req_i`.
- R2: A cycle with `push_i` high stores `pc_i`, and from the next cycle `ret_addr_o` shows that value as the most recent entry.
- R3: A cycle with only `pop_i` high on a non-empty stack removes the most recent entry. The next `ret_addr_o` shows the entry below it, so addresses come back in reverse order of pushing.
- R4: `full_o` is 1 exactly when two entries are held.
- R5: `irq_ok_o` is `irq_req_i` AND NOT `full_o`. A request held off while full is granted in the cycle after a pop frees a level.
- R6: A push while full drops the oldest entry and keeps the stack full. The two most recent pushed values are then returned by two pops, newest first.
- R7: A pop on an empty stack leaves the level count at zero and `ret_addr_o` keeps showing the bottom entry. After it, two pushes are needed to reach `full_o`.
- R8: `push_i` and `pop_i` high together on a non-empty stack replace the most recent entry with `pc_i` and leave the level count unchanged. On an empty stack the same cycle acts as a plain push.
- R9: An asynchronous active-low `rst_n` takes effect at once. Its release is synchronised to `clk` over two flops before the stack leaves reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Save `pc_i` (call or interrupt acknowledge) |
| pop_i | input | 1 | Remove the most recent entry (return) |
| pc_i | input | 11 | Return address to save |
| irq_req_i | input | 1 | A pending, enabled interrupt request |
| ret_addr_o | output | 11 | Most recent entry, or the bottom entry when empty |
| full_o | output | 1 | Both levels occupied |
| irq_ok_o | output | 1 | Interrupt acknowledge may proceed |

## Verification
The main function is swept over every sequence of four operations chosen from idle, push, pop and push-with-pop. The sequences run back to back without reset, so each sequence starts from whatever level the previous one left. The sweep therefore reaches overflow, underflow and replacement from empty, half-full and full levels, and separates a shift-down from a plain write and a saturating pop from a wrapping one. The interrupt request toggles through the sweep so that the hold-off is seen both at full and below it. Directed sequences then check the call/return order, the release of a held interrupt after one return, and the two-push refill after an underflow.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PUSH,
    ACT_SHIFT,
    ACT_POP,
    ACT_REPL
  } stk_act_e;

  // Resolve the strobes against the current occupancy
  function automatic stk_act_e decode_act(input logic push, input logic pop,
                                          input logic empty, input logic full);
    stk_act_e a;
    a = ACT_IDLE;
    if (push && pop && !empty) a = ACT_REPL;
    else if (push && full)     a = ACT_SHIFT;
    else if (push)             a = ACT_PUSH;
    else if (pop && !empty)    a = ACT_POP;
    return a;
  endfunction

endpackage

// File: rtl/rstk_rst_sync.sv
module rstk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rstk_level_ctr.sv
module rstk_level_ctr
  import rstk_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_act_e         act,
  output logic [CNT_W-1:0] level
);
  logic [CNT_W-1:0] level_d;
  logic             level_en;

  always_comb begin
    level_en = 1'b0;
    level_d  = level;
    unique case (act)
      ACT_PUSH: begin level_en = 1'b1; level_d = level + CNT_W'(1); end
      ACT_POP:  begin level_en = 1'b1; level_d = level - CNT_W'(1); end
      default:  begin level_en = 1'b0; level_d = level; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level <= '0;
    else if (level_en) level <= level_d;
  end
endmodule

// File: rtl/rstk_entries.sv
module rstk_entries
  import rstk_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int AW    = 11,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  stk_act_e                  act,
  input  logic [CNT_W-1:0]          level,
  input  logic [AW-1:0]             pc,
  output logic [DEPTH-1:0][AW-1:0]  ent
);
  // Entry 0 is the oldest; a shift moves every entry one place down
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AW-1:0] ent_d;
    logic          ent_en;
    logic [AW-1:0] upper;

    if (i == DEPTH - 1) begin : g_top
      assign upper = pc;
    end else begin : g_mid
      assign upper = ent[i+1];
    end

    always_comb begin
      ent_en = 1'b0;
      ent_d  = ent[i];
      unique case (act)
        ACT_PUSH:  if (level == CNT_W'(i))     begin ent_en = 1'b1; ent_d = pc; end
        ACT_REPL:  if (level == CNT_W'(i + 1)) begin ent_en = 1'b1; ent_d = pc; end
        ACT_SHIFT: begin ent_en = 1'b1; ent_d = upper; end
        default:   begin ent_en = 1'b0; ent_d = ent[i]; end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent[i] <= '0;
      else if (ent_en) ent[i] <= ent_d;
    end
  end
endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top
  import rstk_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int AW    = 11,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] pc_i,
  input  logic          irq_req_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          full_o,
  output logic          irq_ok_o
);
  logic                     core_rst_n;
  logic [CNT_W-1:0]         level;
  logic [DEPTH-1:0][AW-1:0] ent;
  logic                     is_empty;
  logic                     is_full;
  stk_act_e                 act;

  rstk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign is_empty = (level == '0);
  assign is_full  = (level == CNT_W'(DEPTH));
  assign act      = decode_act(push_i, pop_i, is_empty, is_full);

  rstk_level_ctr #(.DEPTH(DEPTH)) u_lvl (
    .clk   (clk),
    .rst_n (core_rst_n),
    .act   (act),
    .level (level)
  );

  rstk_entries #(.DEPTH(DEPTH), .AW(AW)) u_ent (
    .clk   (clk),
    .rst_n (core_rst_n),
    .act   (act),
    .level (level),
    .pc    (pc_i),
    .ent   (ent)
  );

  // Most recent entry; the bottom entry when nothing is held
  always_comb begin
    ret_addr_o = ent[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (level == CNT_W'(i + 1)) ret_addr_o = ent[i];
    end
  end

  assign full_o   = is_full;
  assign irq_ok_o = irq_req_i & ~is_full;
endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] pc_i,
  input logic          irq_req_i,
  input logic [AW-1:0] ret_addr_o,
  input logic          full_o,
  input logic          irq_ok_o
);
  // R2: whatever is pushed is the next visible return address
  a_r2_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> ret_addr_o == $past(pc_i));

  // R3: a lone pop on a full stack frees a level
  a_r3_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && pop_i && !push_i |=> !full_o);

  // R5: no acknowledge while full
  a_r5_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ok_o);

  // R5: a held request is granted right after the freeing pop
  a_r5_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && pop_i && !push_i && irq_req_i |=> (irq_ok_o == irq_req_i));

  // R6: overflowing push keeps the stack full
  a_r6_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && push_i |=> full_o);

  // R8: push with pop below full never fills the stack
  a_r8_repl_level: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !full_o |=> !full_o);

  // R7: a pop without push cannot raise full
  a_r7_pop_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !full_o && pop_i && !push_i |=> !full_o);
endmodule

bind ret_stack_top rstk_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (core_rst_n),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .pc_i       (pc_i),
  .irq_req_i  (irq_req_i),
  .ret_addr_o (ret_addr_o),
  .full_o     (full_o),
  .irq_ok_o   (irq_ok_o)
);

// File: tb/ret_stack_top_tb_top.sv
module ret_stack_top_tb_top;
  localparam int AW = 11;

  logic          clk;
  logic          rst_n;
  logic          push_i;
  logic          pop_i;
  logic [AW-1:0] pc_i;
  logic          irq_req_i;
  logic [AW-1:0] ret_addr_o;
  logic          full_o;
  logic          irq_ok_o;

  int n_chk;
  int n_bad;
  bit done;

  // Behavioural reference
  int            m_lvl;
  logic [AW-1:0] m_ent [2];

  ret_stack_top #(.DEPTH(2), .AW(AW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .pc_i       (pc_i),
    .irq_req_i  (irq_req_i),
    .ret_addr_o (ret_addr_o),
    .full_o     (full_o),
    .irq_ok_o   (irq_ok_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_top();
    return (m_lvl == 0) ? m_ent[0] : m_ent[m_lvl-1];
  endfunction

  function automatic void m_step(input logic ps, input logic pp, input logic [AW-1:0] pc);
    logic pe;
    pe = pp && (m_lvl > 0);
    if (ps && pe) m_ent[m_lvl-1] = pc;
    else if (ps) begin
      if (m_lvl < 2) begin m_ent[m_lvl] = pc; m_lvl++; end
      else begin m_ent[0] = m_ent[1]; m_ent[1] = pc; end
    end else if (pe) m_lvl--;
  endfunction

  // Drive at the falling edge, let one rising edge pass, sample mid-high
  task automatic step(input logic ps, input logic pp, input logic [AW-1:0] pc, input logic irq);
    @(negedge clk);
    push_i = ps; pop_i = pp; pc_i = pc; irq_req_i = irq;
    @(posedge clk);
    m_step(ps, pp, pc);
    #5;
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " ret_addr"}, int'(ret_addr_o), int'(m_top()));
    chk({tag, " full"},     int'(full_o),     int'(m_lvl == 2));
    chk({tag, " irq_ok"},   int'(irq_ok_o),   int'(irq_req_i && (m_lvl != 2)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    m_lvl = 0; m_ent[0] = '0; m_ent[1] = '0;
    push_i = 0; pop_i = 0; pc_i = '0; irq_req_i = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: reset state
    chk("R1 ret_addr", int'(ret_addr_o), 0);
    chk("R1 full", int'(full_o), 0);
    chk("R1 irq_ok", int'(irq_ok_o), 1);

    // R2, R4: two calls fill the stack
    step(1, 0, 11'h123, 1);
    chk("R2 top after first push", int'(ret_addr_o), 'h123);
    chk("R4 not full at one", int'(full_o), 0);
    step(1, 0, 11'h456, 1);
    chk("R2 top after second push", int'(ret_addr_o), 'h456);
    chk("R4 full at two", int'(full_o), 1);
    chk("R5 held while full", int'(irq_ok_o), 0);

    // R6: overflow drops the oldest
    step(1, 0, 11'h789, 1);
    chk("R6 top after overflow", int'(ret_addr_o), 'h789);
    chk("R6 still full", int'(full_o), 1);
    step(0, 1, 11'h000, 1);
    chk("R3 pop order newest first", int'(ret_addr_o), 'h456);
    chk("R5 granted after pop", int'(irq_ok_o), 1);
    step(0, 1, 11'h000, 1);
    chk("R6 oldest dropped, bottom kept", int'(ret_addr_o), 'h456);

    // R7: pop on empty does not wrap
    step(0, 1, 11'h000, 1);
    chk("R7 bottom kept on underflow", int'(ret_addr_o), 'h456);
    chk("R7 not full after underflow", int'(full_o), 0);
    step(1, 0, 11'h0AA, 0);
    chk("R7 one push after underflow not full", int'(full_o), 0);
    step(1, 0, 11'h0BB, 0);
    chk("R7 second push fills", int'(full_o), 1);

    // R8: push with pop replaces the top
    step(1, 1, 11'h0CC, 1);
    chk("R8 top replaced", int'(ret_addr_o), 'h0CC);
    chk("R8 level kept", int'(full_o), 1);
    step(0, 1, 11'h000, 1);
    chk("R8 entry below untouched", int'(ret_addr_o), 'h0AA);

    // Exhaustive sweep: every 4-step sequence of {idle, push, pop, both}, R2 R3 R6 R7 R8
    for (int s = 0; s < 256; s++) begin
      for (int k = 0; k < 4; k++) begin
        int op;
        op = (s >> (2 * k)) & 3;
        step(op[0], op[1], AW'((s * 13 + k * 5 + 1) & 'h7FF), 1'(k ^ s));
        cmp_all("R2/R3 sweep");
      end
    end

    // R9: asynchronous reset clears at once
    @(negedge clk) rst_n = 1'b0;
    #2;
    m_lvl = 0; m_ent[0] = '0; m_ent[1] = '0;
    chk("R9 async clear ret_addr", int'(ret_addr_o), 0);
    chk("R9 async clear full", int'(full_o), 0);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule